// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block keeps track of which virtual page sits in each of a small, fixed number of physical frames and chooses frames according to the Clock (second-chance) policy. Every frame has a stored page number, a valid flag and a use bit. A circular hand rests on the frame that was filled most recently. The engine accepts one page reference at a time. For each reference it reports whether the page was already resident and which frame now holds it. When a resident page has to be displaced, it also reports that page.

Hits, and misses that find an empty frame, are answered in the cycle after the reference is accepted. A miss when every frame is full starts a sweep. The sweep inspects one frame per clock cycle, beginning just past the hand. It gives a second chance to each frame whose use bit is set by clearing that bit, and it takes the first frame whose use bit is already clear. While the sweep runs, the busy output is high and new references are not accepted. The engine only names the victim frame. Moving the data and writing back dirty pages are left to the surrounding logic.

Top module: `clock_repl_engine`

## Requirements
- R1: After reset, busy_o and resp_valid_o are low and every frame is empty. The first reference therefore misses, lands in frame 0 and has evict_valid_o low.
- R2: A reference to a resident page gives a response in the next cycle with hit_o=1, frame_o set to that page's frame and evict_valid_o=0. The hit sets that frame's use bit and leaves the hand where it was.
- R3: A miss while any frame is empty fills the lowest-numbered empty frame. It responds in the next cycle with hit_o=0 and evict_valid_o=0.
- R4: Every newly loaded page gets its use bit set, and the hand is moved to its frame.
- R5: A miss with all frames full searches circularly, starting at the frame after the hand. Each frame whose use bit is set has that bit cleared and is skipped. The first frame found with a clear use bit is replaced, and the response carries evict_valid_o=1 and evict_page_o set to the page it held.
- R6: The sweep inspects one frame per cycle. If the victim is the k-th frame inspected, the response comes k cycles later than it would for a hit, and busy_o stays high in the meantime.
- R7: References presented while busy_o is high are ignored. They are not answered and do not change the frame contents.
- R8: The frame count is a parameter, and both 3 and 4 frames are supported. With 3 frames, the sequence 1,2,3,4,2,5,6 leaves pages 4,6,5 in frames 0,1,2. With 4 frames, the sequence 1,2,3,4,1,5,3,6,7,6,8 leaves pages 5,6,8,7 in frames 0 to 3.
- R9: resp_valid_o is a single-cycle pulse for each accepted reference, and it is never high in the same cycle as busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A page reference is presented |
| req_page_i | input | PAGE_W | Referenced page number |
| busy_o | output | 1 | Sweep in progress; references are ignored |
| resp_valid_o | output | 1 | One-cycle result strobe |
| hit_o | output | 1 | The page was already resident |
| frame_o | output | IDX_W | Frame that now holds the referenced page |
| evict_valid_o | output | 1 | A resident page was displaced |
| evict_page_o | output | PAGE_W | Page number that was displaced |

## Verification
The assertions check the following on every cycle: no page is ever resident in two frames, a result strobe never coincides with busy, a hit never reports an eviction, a hit leaves the hand where it was, and each sweep step clears the use bit it passed over. They also check that every answered frame has its use bit set and that a load moves the hand onto the loaded frame. Only the bench's scenarios can show which frame the policy actually picks, the order of the fill, the sweep latency and the final frame contents. To do this, the bench runs 3-frame and 4-frame instances against an independent model of the policy on the two fixed sequences and on long pseudo-random reference streams. It also presents references while busy is high.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;
  typedef enum logic {
    CRP_IDLE  = 1'b0,
    CRP_SWEEP = 1'b1
  } crp_state_e;
endpackage

// File: rtl/crp_lookup.sv
module crp_lookup #(
  parameter int unsigned NUM_FRAMES = 4,
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned IDX_W      = 2
) (
  input  logic [PAGE_W-1:0]     page_i,
  input  logic [PAGE_W-1:0]     pages_i [NUM_FRAMES],
  input  logic [NUM_FRAMES-1:0] valid_i,
  output logic [NUM_FRAMES-1:0] match_o,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      idx_o
);
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (pages_i[g] == page_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_FRAMES; i++)
      if (match_o[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/crp_free_finder.sv
module crp_free_finder #(
  parameter int unsigned NUM_FRAMES = 4,
  parameter int unsigned IDX_W      = 2
) (
  input  logic [NUM_FRAMES-1:0] valid_i,
  output logic                  free_o,
  output logic [IDX_W-1:0]      idx_o
);
  assign free_o = ~&valid_i;

  // scan downward so the lowest empty frame wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--)
      if (!valid_i[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/clock_repl_engine.sv
module clock_repl_engine
  import clock_repl_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 4,
  parameter int unsigned PAGE_W     = 8,
  localparam int unsigned IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PAGE_W-1:0] req_page_i,
  output logic              busy_o,
  output logic              resp_valid_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  frame_o,
  output logic              evict_valid_o,
  output logic [PAGE_W-1:0] evict_page_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  logic [PAGE_W-1:0]     page_q [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] valid_q, use_q;
  logic [IDX_W-1:0]      hand_q, ptr_q;
  logic [PAGE_W-1:0]     pend_q;
  crp_state_e            state_q;

  logic [NUM_FRAMES-1:0] match_vec;
  logic                  hit_any, free_any;
  logic [IDX_W-1:0]      hit_idx, free_idx;
  logic                  accept;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  crp_lookup #(.NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_lookup (
    .page_i  (req_page_i),
    .pages_i (page_q),
    .valid_i (valid_q),
    .match_o (match_vec),
    .hit_o   (hit_any),
    .idx_o   (hit_idx)
  );

  crp_free_finder #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_free (
    .valid_i (valid_q),
    .free_o  (free_any),
    .idx_o   (free_idx)
  );

  assign accept = req_valid_i && (state_q == CRP_IDLE);
  assign busy_o = (state_q == CRP_SWEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_FRAMES; i++) page_q[i] <= '0;
      valid_q       <= '0;
      use_q         <= '0;
      hand_q        <= LAST_IDX;
      ptr_q         <= '0;
      pend_q        <= '0;
      state_q       <= CRP_IDLE;
      resp_valid_o  <= 1'b0;
      hit_o         <= 1'b0;
      frame_o       <= '0;
      evict_valid_o <= 1'b0;
      evict_page_o  <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      case (state_q)
        CRP_IDLE: begin
          if (accept) begin
            if (hit_any) begin
              use_q[hit_idx] <= 1'b1;
              resp_valid_o   <= 1'b1;
              hit_o          <= 1'b1;
              frame_o        <= hit_idx;
              evict_valid_o  <= 1'b0;
            end else if (free_any) begin
              page_q[free_idx]  <= req_page_i;
              valid_q[free_idx] <= 1'b1;
              use_q[free_idx]   <= 1'b1;
              hand_q            <= free_idx;
              resp_valid_o      <= 1'b1;
              hit_o             <= 1'b0;
              frame_o           <= free_idx;
              evict_valid_o     <= 1'b0;
            end else begin
              pend_q  <= req_page_i;
              ptr_q   <= step_idx(hand_q);
              state_q <= CRP_SWEEP;
            end
          end
        end
        CRP_SWEEP: begin
          if (use_q[ptr_q]) begin
            use_q[ptr_q] <= 1'b0;  // second chance
            ptr_q        <= step_idx(ptr_q);
          end else begin
            page_q[ptr_q] <= pend_q;
            use_q[ptr_q]  <= 1'b1;
            hand_q        <= ptr_q;
            resp_valid_o  <= 1'b1;
            hit_o         <= 1'b0;
            frame_o       <= ptr_q;
            evict_valid_o <= 1'b1;
            evict_page_o  <= page_q[ptr_q];
            state_q       <= CRP_IDLE;
          end
        end
        default: state_q <= CRP_IDLE;
      endcase
    end
  end

  // R5: a page is never resident in two frames
  a_r5_unique_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  // R9: strobe never overlaps busy
  a_r9_resp_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !busy_o);

  // R2: hits report no eviction
  a_r2_hit_no_evict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && hit_o) |-> !evict_valid_o);

  // R2: hand holds on a hit
  a_r2_hand_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit_any) |=> $stable(hand_q));

  // R4: answered frame has its use bit set; loads move the hand there
  a_r4_use_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> use_q[frame_o]);
  a_r4_hand_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !hit_o) |-> (hand_q == frame_o));

  // R6: each sweep step clears the bit it passed
  a_r6_sweep_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && use_q[ptr_q]) |=> !use_q[$past(ptr_q)]);

  // R7: nothing is accepted while busy
  a_r7_busy_holds_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(pend_q));
endmodule

// File: tb/clock_repl_engine_test.sv
module clock_repl_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       rv   [2];
  logic [7:0] rp   [2];
  logic       busy [2];
  logic       resp [2];
  logic       hit  [2];
  logic [1:0] frm  [2];
  logic       evv  [2];
  logic [7:0] evp  [2];

  clock_repl_engine #(.NUM_FRAMES(4), .PAGE_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv[0]), .req_page_i(rp[0]),
    .busy_o(busy[0]), .resp_valid_o(resp[0]), .hit_o(hit[0]), .frame_o(frm[0]),
    .evict_valid_o(evv[0]), .evict_page_o(evp[0]));

  clock_repl_engine #(.NUM_FRAMES(3), .PAGE_W(8)) uut3 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv[1]), .req_page_i(rp[1]),
    .busy_o(busy[1]), .resp_valid_o(resp[1]), .hit_o(hit[1]), .frame_o(frm[1]),
    .evict_valid_o(evv[1]), .evict_page_o(evp[1]));

  int checks = 0;
  int errors = 0;
  int nf [2] = '{4, 3};
  int m_pg [2][4];
  bit m_v  [2][4];
  bit m_u  [2][4];
  int m_hand [2];
  int last_frame;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 2; s++) begin
      m_hand[s] = nf[s] - 1;
      for (int i = 0; i < 4; i++) begin
        m_pg[s][i] = 0; m_v[s][i] = 0; m_u[s][i] = 0;
      end
    end
  endtask

  task automatic do_ref(input int s, input int page, input bit poke);
    int e_frame = -1, e_lat = 0, e_evp = 0, lat = 0, n = nf[s];
    bit e_hit = 0, e_evv = 0, saw_busy = 0;
    for (int i = 0; i < n; i++)
      if (m_v[s][i] && m_pg[s][i] == page) begin e_hit = 1; e_frame = i; end
    if (e_hit) m_u[s][e_frame] = 1;
    else begin
      for (int i = n - 1; i >= 0; i--) if (!m_v[s][i]) e_frame = i;
      if (e_frame < 0) begin
        int p = (m_hand[s] + 1) % n;
        forever begin
          e_lat++;
          if (m_u[s][p]) begin m_u[s][p] = 0; p = (p + 1) % n; end
          else break;
        end
        e_frame = p; e_evv = 1; e_evp = m_pg[s][p];
      end
      m_pg[s][e_frame] = page; m_v[s][e_frame] = 1;
      m_u[s][e_frame] = 1; m_hand[s] = e_frame;
    end

    @(negedge clk); rv[s] = 1'b1; rp[s] = 8'(page);
    @(negedge clk); rv[s] = 1'b0;
    while (!resp[s] && lat < 50) begin
      if (busy[s]) begin
        saw_busy = 1;
        if (poke) begin rv[s] = 1'b1; rp[s] = 8'd200; end
      end
      @(negedge clk); lat++;
    end
    rv[s] = 1'b0;
    chk(resp[s] == 1'b1, "R9 response present", int'(resp[s]), 1);
    chk(hit[s] == e_hit, e_hit ? "R2 hit flag" : "R3/R5 miss flag", int'(hit[s]), int'(e_hit));
    chk(int'(frm[s]) == e_frame, e_hit ? "R2 frame" : (e_evv ? "R5 victim frame" : "R3 fill frame"),
        int'(frm[s]), e_frame);
    chk(evv[s] == e_evv, "R5 evict valid", int'(evv[s]), int'(e_evv));
    if (e_evv) chk(int'(evp[s]) == e_evp, "R5 evict page", int'(evp[s]), e_evp);
    chk(lat == e_lat, "R6 sweep latency", lat, e_lat);
    chk(saw_busy == (e_lat > 0), "R6 busy during sweep", int'(saw_busy), int'(e_lat > 0));
    last_frame = int'(frm[s]);
    @(negedge clk);
    chk(resp[s] == 1'b0, "R9 single pulse", int'(resp[s]), 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seq4 [11] = '{1, 2, 3, 4, 1, 5, 3, 6, 7, 6, 8};
    int seq3 [7]  = '{1, 2, 3, 4, 2, 5, 6};
    int fin4 [4]  = '{5, 6, 8, 7};
    int fin3 [3]  = '{4, 6, 5};
    logic [15:0] lfsr = 16'hACE1;
    rv[0] = 0; rv[1] = 0; rp[0] = 0; rp[1] = 0;
    model_reset();
    repeat (2) @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      chk(busy[s] == 1'b0, "R1 busy after reset", int'(busy[s]), 0);
      chk(resp[s] == 1'b0, "R1 resp after reset", int'(resp[s]), 0);
    end
    rst_n = 1'b1;

    // R1/R8: fixed sequences from reset
    for (int i = 0; i < 11; i++) do_ref(0, seq4[i], 0);
    for (int i = 0; i < 4; i++) begin
      do_ref(0, fin4[i], 0);
      chk(last_frame == i, "R8 final contents 4 frames", last_frame, i);
    end
    for (int i = 0; i < 7; i++) do_ref(1, seq3[i], 0);
    for (int i = 0; i < 3; i++) begin
      do_ref(1, fin3[i], 0);
      chk(last_frame == i, "R8 final contents 3 frames", last_frame, i);
    end

    // R7: drive references while busy, then confirm page 200 never entered
    for (int s = 0; s < 2; s++) begin
      do_ref(s, 9, 1);
      do_ref(s, 200, 0);
      chk(hit[s] == 1'b0, "R7 ignored reference not resident", int'(hit[s]), 0);
    end

    // R4/R5: pseudo-random streams over a small page alphabet
    for (int k = 0; k < 600; k++) begin
      int s = k % 2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_ref(s, 1 + int'(lfsr[3:0]) % (nf[s] + 2), lfsr[7]);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule